// File: doc/BRIEF.md
# I2C Register-Access Target with Auto-Increment

This block is an I2C target that gives a bus master byte-wide read and write access to a 16-entry register space. SCL and SDA arrive as raw levels that the block oversamples with its own clock. The block answers the bus by asserting an SDA pull-down enable. On the register side it presents a 4-bit register pointer and a one-cycle write strobe with its data byte. It takes a read-data byte from the register file. The register contents themselves sit outside the block.

The first byte after an accepted write address is taken as a command. Its low four bits set the pointer and its top bit sets the auto-increment flag. Bytes that follow in the same write go to the pointed registers. A read uses a combined format: a write address, a command byte, a repeated START, the read address, and then the data bytes. When auto-increment is on, the pointer steps after every data byte and wraps from 15 back to 0.

The target answers two addresses. One is set by a 4-bit strap input under three fixed upper bits, or is a fixed address when straps are disabled. The other is a shared all-call address that only accepts writes.

Top module: `i2ct_target`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ptr` is 0, `sda_pull` is low and `wr_stb` is low. The command register resets to 00h, so auto-increment is off. A reset asserted in the middle of a transfer releases SDA at once.
- R2: An address byte whose upper seven bits equal {ADDR_HI, strap} is acknowledged for both directions. Bit 0 of that byte selects the direction: 1 means read, 0 means write. A changed strap value takes effect for the next address. Any other address is not acknowledged, and the block ignores the bus until the next START, so no byte of that transfer is acknowledged or strobed.
- R3: The all-call address ALL_CALL is acknowledged when bit 0 is 0 (write), and the bytes that follow are handled as for the device's own address. With bit 0 equal to 1 it is not acknowledged.
- R4: The first byte after an acknowledged write address is acknowledged and loads the command register. Bits 3:0 become `ptr` and bit 7 becomes the auto-increment flag. Bits 6:4 have no effect.
- R5: Every later byte of a write is acknowledged. For each such byte, `wr_stb` is high for exactly one clock cycle, with that byte on `wr_data` and the target register on `ptr`.
- R6: A written byte whose target pointer has its bit set in RO_MASK (default: registers 0, 1, 14 and 15) is acknowledged, but `wr_stb` stays low for it.
- R7: With auto-increment on, the pointer advances by one after each data byte, read or written, and wraps from 15 to 0. With auto-increment off it stays on the same register.
- R8: After the read address is acknowledged, each byte is taken from `rd_data` at the falling SCL edge that ends the preceding acknowledge bit. The byte is then shifted out MSB first.
- R9: A master NACK on a read byte ends the transfer. SDA stays released until the next START.
- R10: `sda_pull` changes only just after a detected falling SCL edge, never while SCL is high.
- R11: A STOP returns the bus logic to idle. Pointer and flag are kept, so a later read without a command byte resumes from the retained pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_pull | output | 1 | 1 = pull SDA low |
| strap | input | STRAP_W (4) | Address-select strap, low bits of the device address |
| ptr | output | PTR_W (4) | Current register pointer |
| wr_stb | output | 1 | One-cycle write strobe for the register at `ptr` |
| wr_data | output | 8 | Byte to be written |
| rd_data | input | 8 | Contents of the register at `ptr` |

## Verification
The hardest cases to reach from the ports are the pointer wrap during a combined read and a reset that lands while the block is driving an acknowledge. The wrap only shows up when the command selects register 15 with auto-increment on and the master keeps acknowledging past it. The bench steers a directed read there and checks that the second byte comes from register 0. For the reset case, the bench stops the master model after the address byte, while the target is holding SDA low. It asserts reset at that point and then checks that the pull-down and the pointer return to their defaults. Random mixes of writes, combined reads, command flags and byte counts then cover pointer sequences over read-only and writable registers.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int AI_BIT = 7;

    // Transfer phase of the target
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WR,
        PH_RD
    } phase_t;

    // Synchronized bus level and detected events
    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic cmd_ai(input logic [BYTE_W-1:0] c);
        return c[AI_BIT];
    endfunction

endpackage

// File: rtl/i2ct_bus_sense.sv
module i2ct_bus_sense
    import i2ct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);

    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] prv;

    assign raw = {scl_raw, sda_raw};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '1;
            else     sh <= {sh[STAGES-1:0], raw[g]};
        end
        assign lvl[g] = sh[STAGES-1];
        assign prv[g] = sh[STAGES];
    end

    // index 1 = SCL, index 0 = SDA
    always_comb begin
        ev.sda   = lvl[0];
        ev.rise  =  lvl[1] & ~prv[1];
        ev.fall  = ~lvl[1] &  prv[1];
        ev.start =  lvl[1] &  prv[1] & ~lvl[0] &  prv[0];
        ev.stop  =  lvl[1] &  prv[1] &  lvl[0] & ~prv[0];
    end

endmodule

// File: rtl/i2ct_addr_match.sv
module i2ct_addr_match
    import i2ct_pkg::*;
#(
    parameter int                      STRAP_W    = 4,
    parameter bit                      USE_STRAP  = 1'b1,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI  = 3'b010,
    parameter logic [ADDR_W-1:0]       FIXED_ADDR = 7'h20,
    parameter logic [ADDR_W-1:0]       ALL_CALL   = 7'h68
) (
    input  logic [BYTE_W-1:0]  addr_byte,
    input  logic [STRAP_W-1:0] strap,
    output logic               hit
);

    logic [ADDR_W-1:0] own;

    if (USE_STRAP) begin : g_strap
        assign own = {ADDR_HI, strap};
    end else begin : g_fixed
        logic unused_strap;
        assign unused_strap = ^strap;
        assign own = FIXED_ADDR;
    end

    always_comb begin
        hit = (addr_byte[BYTE_W-1:1] == own)
            | ((addr_byte[BYTE_W-1:1] == ALL_CALL) & ~addr_byte[0]);
    end

endmodule

// File: rtl/i2ct_cmd_ptr.sv
module i2ct_cmd_ptr #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic             load_ai,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr,
    output logic             ai
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            ai  <= 1'b0;
        end else if (load) begin
            ptr <= load_ptr;
            ai  <= load_ai;
        end else if (adv && ai) begin
            ptr <= ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
    import i2ct_pkg::*;
#(
    parameter int                        STRAP_W    = 4,
    parameter int                        PTR_W      = 4,
    parameter bit                        USE_STRAP  = 1'b1,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI    = 3'b010,
    parameter logic [ADDR_W-1:0]         FIXED_ADDR = 7'h20,
    parameter logic [ADDR_W-1:0]         ALL_CALL   = 7'h68,
    parameter logic [(1<<PTR_W)-1:0]     RO_MASK    = 16'hC003
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic [STRAP_W-1:0] strap,
    output logic [PTR_W-1:0]   ptr,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0]  rd_data
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    bus_ev_t           ev;
    phase_t            phase;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-2:0] rd_sh;
    logic              in_ack;
    logic              rd_mode;
    logic              mack;
    logic              hit;
    logic              cmd_ai_q;
    logic              cmd_load;
    logic              ptr_adv;
    logic              ack_exit;
    logic              byte_end;
    logic              scl_fall;
    logic              in_idle;

    i2ct_bus_sense #(.STAGES(2)) u_sense (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .ev      (ev)
    );

    i2ct_addr_match #(
        .STRAP_W    (STRAP_W),
        .USE_STRAP  (USE_STRAP),
        .ADDR_HI    (ADDR_HI),
        .FIXED_ADDR (FIXED_ADDR),
        .ALL_CALL   (ALL_CALL)
    ) u_match (
        .addr_byte (shreg),
        .strap     (strap),
        .hit       (hit)
    );

    i2ct_cmd_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd_load),
        .load_ptr (shreg[PTR_W-1:0]),
        .load_ai  (cmd_ai(shreg)),
        .adv      (ptr_adv),
        .ptr      (ptr),
        .ai       (cmd_ai_q)
    );

    logic unused_ai;
    assign unused_ai = cmd_ai_q;

    assign scl_fall = ev.fall;
    assign in_idle  = (phase == PH_IDLE);

    always_comb begin
        ack_exit = ev.fall && in_ack && !ev.start && !ev.stop;
        byte_end = ev.fall && !in_ack && (bitcnt == LAST_BIT);
        cmd_load = byte_end && (phase == PH_CMD);
        ptr_adv  = ack_exit && ((phase == PH_WR)
                              || (phase == PH_ADDR && rd_mode)
                              || (phase == PH_RD && mack));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rd_sh    <= '0;
            in_ack   <= 1'b0;
            rd_mode  <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ev.start) begin
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.rise) begin
                    if (in_ack) begin
                        mack <= !ev.sda;
                    end else if (bitcnt != LAST_BIT) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end
                end
                if (ack_exit) begin
                    in_ack   <= 1'b0;
                    bitcnt   <= '0;
                    sda_pull <= 1'b0;
                    unique case (phase)
                        PH_ADDR: begin
                            if (rd_mode) begin
                                phase    <= PH_RD;
                                rd_sh    <= rd_data[BYTE_W-2:0];
                                sda_pull <= !rd_data[BYTE_W-1];
                            end else begin
                                phase <= PH_CMD;
                            end
                        end
                        PH_CMD: phase <= PH_WR;
                        PH_RD: begin
                            if (mack) begin
                                rd_sh    <= rd_data[BYTE_W-2:0];
                                sda_pull <= !rd_data[BYTE_W-1];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end else if (byte_end) begin
                    unique case (phase)
                        PH_ADDR: begin
                            if (hit) begin
                                in_ack   <= 1'b1;
                                sda_pull <= 1'b1;
                                rd_mode  <= shreg[0];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        PH_CMD: begin
                            in_ack   <= 1'b1;
                            sda_pull <= 1'b1;
                        end
                        PH_WR: begin
                            in_ack   <= 1'b1;
                            sda_pull <= 1'b1;
                            wr_stb   <= !RO_MASK[ptr];
                            wr_data  <= shreg;
                        end
                        PH_RD: begin
                            in_ack   <= 1'b1;
                            sda_pull <= 1'b0;
                        end
                        default: ;
                    endcase
                end else if (ev.fall && phase == PH_RD && !in_ack) begin
                    rd_sh    <= {rd_sh[BYTE_W-3:0], 1'b0};
                    sda_pull <= !rd_sh[BYTE_W-2];
                end
            end
        end
    end

endmodule

// File: rtl/i2ct_checks.sv
module i2ct_checks #(
    parameter int                    PTR_W   = 4,
    parameter logic [(1<<PTR_W)-1:0] RO_MASK = 16'hC003
) (
    input logic             clk,
    input logic             rst,
    input logic [PTR_W-1:0] ptr,
    input logic             sda_pull,
    input logic             wr_stb,
    input logic             scl_fall,
    input logic             in_idle
);

    AST_RST_DEFAULT: assert property (@(posedge clk)
        rst |=> (ptr == '0 && !sda_pull && !wr_stb)); // R1

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R5

    AST_RO_NO_STB: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !RO_MASK[ptr]); // R6

    AST_PTR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr) |-> $past(scl_fall)); // R7

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        in_idle |-> !sda_pull); // R9

    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(scl_fall)); // R10

endmodule

bind i2ct_target i2ct_checks #(
    .PTR_W   (PTR_W),
    .RO_MASK (RO_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ptr      (ptr),
    .sda_pull (sda_pull),
    .wr_stb   (wr_stb),
    .scl_fall (scl_fall),
    .in_idle  (in_idle)
);

// File: tb/sim_i2ct_target.sv
module sim_i2ct_target;

    localparam int         Q        = 6;
    localparam logic [2:0] HI       = 3'b010;
    localparam logic [6:0] ALLC     = 7'h68;
    localparam logic [15:0] ROM     = 16'hC003;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [3:0] strap = 4'h5;
    logic       sda_pull;
    logic [3:0] ptr;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       sda_line;

    logic [7:0] regs     [16];
    logic [7:0] exp_regs [16];
    logic [3:0] exp_ptr = 4'h0;
    logic       exp_ai  = 1'b0;
    int nchk = 0, nfail = 0, nstb = 0, viol = 0;
    bit done = 1'b0;
    logic pull_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;
    assign rd_data  = regs[ptr];

    i2ct_target u0 (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .strap(strap), .ptr(ptr),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data)
    );

    // register file environment and SDA-change monitor (R10)
    always @(negedge clk) begin
        if (wr_stb) begin
            regs[ptr] <= wr_data;
            nstb <= nstb + 1;
        end
        if (!rst && sda_pull != pull_prev && m_scl) viol <= viol + 1;
        pull_prev <= sda_pull;
    end

    function automatic logic [7:0] init_val(input int i);
        return 8'(8'h31 + i * 13);
    endfunction

    function automatic logic [3:0] nxt(input logic [3:0] p, input logic a);
        return a ? p + 4'd1 : p;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        send_bits(b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        ack = !sda_line; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q); m_scl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); m_scl = 1'b0;
        end
        m_sda = mack ? 1'b0 : 1'b1; tick(Q); m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q); m_sda = 1'b1;
    endtask

    task automatic cmp_regs(input string req);
        int bad = 0;
        for (int i = 0; i < 16; i++) if (regs[i] !== exp_regs[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input int n,
                            input bit exp_ack, input string req);
        bit ack;
        logic [7:0] d;
        i2c_start();
        write_byte({a, 1'b0}, ack);
        chk(ack == exp_ack, req, ack, exp_ack);
        if (exp_ack) begin
            write_byte(cmd, ack);
            chk(ack, "R4 command ack", ack, 1);
            exp_ptr = cmd[3:0];
            exp_ai  = cmd[7];
            for (int k = 0; k < n; k++) begin
                d = 8'($urandom);
                write_byte(d, ack);
                chk(ack, "R5 data ack", ack, 1);
                if (!ROM[exp_ptr]) exp_regs[exp_ptr] = d;
                exp_ptr = nxt(exp_ptr, exp_ai);
            end
        end
        i2c_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] cmd, input bit use_cmd,
                           input int n, input string req);
        bit ack;
        logic [7:0] d;
        i2c_start();
        if (use_cmd) begin
            write_byte({a, 1'b0}, ack);
            chk(ack, "R2 write address ack", ack, 1);
            write_byte(cmd, ack);
            chk(ack, "R4 command ack", ack, 1);
            exp_ptr = cmd[3:0];
            exp_ai  = cmd[7];
            i2c_start();
        end
        write_byte({a, 1'b1}, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, d);
            chk(d == exp_regs[exp_ptr], req, d, exp_regs[exp_ptr]);
            exp_ptr = nxt(exp_ptr, exp_ai);
        end
        tick(Q);
        chk(sda_pull == 1'b0, "R9 released after NACK", sda_pull, 0);
        i2c_stop();
    endtask

    initial begin
        bit ack;
        int s0;
        logic [6:0] dev;
        s0 = $urandom(32'd2024);
        for (int i = 0; i < 16; i++) begin
            regs[i]     = init_val(i);
            exp_regs[i] = init_val(i);
        end
        dev = {HI, strap};
        tick(6);
        chk(ptr == 4'h0 && sda_pull == 1'b0 && wr_stb == 1'b0, "R1 reset state", {ptr, sda_pull, wr_stb}, 0);
        rst = 1'b0;
        tick(6);
        chk(ptr == 4'h0 && sda_pull == 1'b0 && nstb == 0, "R1 after reset", {ptr, sda_pull}, 0);

        // R4: bits 6:4 ignored, AI clear keeps pointer (R7)
        do_write(dev, 8'h7A, 2, 1'b1, "R2 own address write");
        chk(ptr == 4'hA, "R4 pointer from command", ptr, 4'hA);
        cmp_regs("R7 no increment with flag clear");

        // R7: wrap from 15 to 0 during a combined read (R8)
        do_read(dev, 8'h8F, 1'b1, 2, "R8 read data with wrap");
        chk(ptr == 4'h1, "R7 pointer wrapped", ptr, 4'h1);

        // R11: read without command resumes at retained pointer
        do_read(dev, 8'h00, 1'b0, 1, "R11 resume from retained pointer");
        chk(ptr == 4'h2, "R11 pointer after resume", ptr, 4'h2);

        // R2: foreign address ignored
        s0 = nstb;
        i2c_start();
        write_byte({dev ^ 7'h01, 1'b0}, ack);
        chk(!ack, "R2 foreign address NACK", ack, 0);
        write_byte(8'h83, ack);
        chk(!ack, "R2 ignored until START", ack, 0);
        i2c_stop();
        chk(nstb == s0, "R2 no strobe", nstb, s0);

        // R3: all-call write accepted, read refused
        do_write(ALLC, 8'h8A, 2, 1'b1, "R3 all-call write ack");
        cmp_regs("R3 all-call write data");
        i2c_start();
        write_byte({ALLC, 1'b1}, ack);
        chk(!ack, "R3 all-call read NACK", ack, 0);
        i2c_stop();

        // R6: read-only targets acknowledged but not strobed
        s0 = nstb;
        do_write(dev, 8'h80, 3, 1'b1, "R2 own address write");
        chk(nstb == s0 + 1, "R6 strobes skip read-only", nstb, s0 + 1);
        cmp_regs("R6 read-only untouched");

        // R2: strap change moves the address
        strap = 4'hC;
        do_write(dev, 8'h05, 0, 1'b0, "R2 old address refused");
        dev = {HI, strap};
        do_write(dev, 8'h85, 2, 1'b1, "R2 new strap address ack");
        cmp_regs("R5 write data");

        // R1: reset while driving ACK
        do_write(dev, 8'h09, 0, 1'b1, "R2 own address write");
        i2c_start();
        send_bits({dev, 1'b0});
        tick(Q);
        chk(sda_pull == 1'b1, "R2 ACK driven", sda_pull, 1);
        rst = 1'b1;
        tick(2);
        chk(sda_pull == 1'b0 && ptr == 4'h0, "R1 mid-transfer reset", {ptr, sda_pull}, 0);
        rst = 1'b0;
        exp_ptr = 4'h0;
        exp_ai  = 1'b0;
        i2c_stop();

        // random mix
        for (int it = 0; it < 20; it++) begin
            logic [7:0] cmd;
            int n;
            cmd = {1'($urandom), 3'($urandom), 4'($urandom)};
            n   = 1 + int'($urandom % 4);
            if ($urandom % 2) begin
                do_write(dev, cmd, n, 1'b1, "R2 own address write");
                cmp_regs("R7 random write sequence");
            end else begin
                do_read(dev, cmd, 1'b1, n, "R8 random read sequence");
            end
            chk(ptr == exp_ptr, "R7 pointer after transfer", ptr, exp_ptr);
        end

        chk(viol == 0, "R10 SDA changed with SCL high", viol, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule